// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog counter that firmware controls through a small synchronous register bus. A free-running up-counter advances on a slow tick strobe, optionally divided by a power-of-two prescaler. When the counter passes its all-ones value while the watchdog is armed, the block raises a one-clock reset pulse and restarts the count from a programmable start value. Firmware keeps the system alive by writing a fresh value to a kick register, which restarts the count.

Arming and disarming take an ordered pair of key words written to one register. Every register write is posted. The write is held in a shadow slot and takes effect on the second tick strobe after it is made. A status register shows which of the four writable slots still hold a write that has not taken effect. While the watchdog is armed, the prescaler and start-value registers are locked, so a stray write cannot stretch the timeout.

Top module: `key_wdt`

## Requirements
- R1: A committed write of 32'h0000_BBBB to the key register (address 3), followed by a committed write of 32'h0000_4444 as the very next committed key write, arms the watchdog. Arming loads the counter from the start-value register and clears the prescaler phase.
- R2: A committed 32'h0000_AAAA followed by a committed 32'h0000_5555 as the next key write disarms the watchdog. The counter then holds its value.
- R3: While the watchdog is armed, a committed write to the control register (address 0) or the start-value register (address 1) leaves that register unchanged.
- R4: The counter (read at address 2) changes only on a tick strobe, and only while armed. With control bit 3 clear it steps on every tick. With bit 3 set it steps once per 2^N ticks, where N is control bits 2:0.
- R5: A committed write to the kick register (address 4) reloads the counter from the start-value register only when the written value differs from the previous kick value. Reading address 4 returns the last kick value, which is 0 after reset.
- R6: Reading address 5 returns the pending flags: bit 0 for control, bit 1 for start value, bit 2 for key and bit 3 for kick. A flag sets on a bus write to its register and clears when the write commits, on the second tick after that write. A newer write to the same register replaces the held value and restarts its wait. All bits read 0 when nothing is pending.
- R7: A key word that does not complete a started pair ends the sequence without changing the armed state. An unrecognised key word on its own has no effect either.
- R8: When the counter steps past all ones while armed, `wdt_rst` is high for the one clock after that tick, and the counter restarts from the start value.
- R9: After reset the watchdog is disarmed, the start value is 32'hFFFF_FFFF, and control, counter, kick value, pending flags and `wdt_rst` are all 0. Addresses 3, 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow timebase strobe, one clock wide |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst | output | 1 | Overflow reset pulse |

## Verification
The hardest state to reach is a collision between posted writes and the key sequence. Examples are a key write that overwrites a held key word before it commits, or a kick and an arming word that commit on the same tick while the counter is about to wrap. The random phase draws key words mostly from the four magic values. It keeps start values within a few counts of all ones and leaves only short gaps between writes and ticks, so these overlaps and wraps happen many times. Directed sequences first walk through arming, locking, kick filtering, an aborted pair and a full overflow.

// File: rtl/key_wdt.sv
module key_wdt #(
  parameter int DATA_W  = 32,
  parameter int RATIO_W = 3,
  parameter int SETTLE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst
);
  localparam int CTRL_W = RATIO_W + 1;
  localparam int PRE_W  = (1 << RATIO_W) - 1;
  localparam int AGE_W  = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam int NCH    = 4;
  localparam int CH_CTRL = 0, CH_LOAD = 1, CH_KEY = 2, CH_KICK = 3;
  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_CNT = 3'd2,
                         A_KEY = 3'd3, A_KICK = 3'd4, A_PEND = 3'd5;
  localparam logic [DATA_W-1:0] ON1  = DATA_W'(16'hBBBB);
  localparam logic [DATA_W-1:0] ON2  = DATA_W'(16'h4444);
  localparam logic [DATA_W-1:0] OFF1 = DATA_W'(16'hAAAA);
  localparam logic [DATA_W-1:0] OFF2 = DATA_W'(16'h5555);

  typedef enum logic [1:0] {K_IDLE, K_ON, K_OFF} kst_t;

  logic                run;
  kst_t                kst;
  logic [CTRL_W-1:0]   ctrl;
  logic [DATA_W-1:0]   load, count, last_kick;
  logic [PRE_W-1:0]    pre_cnt;
  logic [NCH-1:0]      pend, due;
  logic [DATA_W-1:0]   shadow [NCH];

  function automatic logic [2:0] ch_addr(input int ch);
    case (ch)
      CH_CTRL: return A_CTRL;
      CH_LOAD: return A_LOAD;
      CH_KEY:  return A_KEY;
      default: return A_KICK;
    endcase
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_post
    logic [DATA_W-1:0] sh;
    logic              p;
    logic [AGE_W-1:0]  ag;
    wire hit = bus_we && (bus_addr == ch_addr(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh <= '0; p <= 1'b0; ag <= '0;
      end else if (hit) begin
        sh <= bus_wdata; p <= 1'b1; ag <= '0;
      end else if (p && tick) begin
        if (ag == AGE_W'(SETTLE - 1)) p <= 1'b0;
        else ag <= ag + 1'b1;
      end
    end
    assign pend[i]   = p;
    assign shadow[i] = sh;
    assign due[i]    = p && tick && (ag == AGE_W'(SETTLE - 1));
  end

  wire              pre_en   = ctrl[CTRL_W-1];
  wire [PRE_W-1:0]  pre_mask = ~({PRE_W{1'b1}} << ctrl[RATIO_W-1:0]);
  wire              step     = tick && run && (!pre_en || pre_cnt == pre_mask);
  wire              wrap     = step && (count == '1);
  wire [DATA_W-1:0] key      = shadow[CH_KEY];

  logic unused_ctrl_hi;
  assign unused_ctrl_hi = ^shadow[CH_CTRL][DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; kst <= K_IDLE; ctrl <= '0; load <= '1;
      count <= '0; pre_cnt <= '0; last_kick <= '0; wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= wrap;
      if (tick && run) begin
        if (step) pre_cnt <= '0;
        else      pre_cnt <= pre_cnt + 1'b1;
      end
      if (step) count <= wrap ? load : count + 1'b1;
      if (due[CH_CTRL] && !run) ctrl <= shadow[CH_CTRL][CTRL_W-1:0];
      if (due[CH_LOAD] && !run) load <= shadow[CH_LOAD];
      if (due[CH_KICK]) begin
        last_kick <= shadow[CH_KICK];
        if (shadow[CH_KICK] != last_kick) count <= load;
      end
      if (due[CH_KEY]) begin
        case (kst)
          K_IDLE:  kst <= (key == ON1) ? K_ON : (key == OFF1) ? K_OFF : K_IDLE;
          K_ON: begin
            kst <= K_IDLE;
            if (key == ON2) begin
              run <= 1'b1; count <= load; pre_cnt <= '0;
            end
          end
          default: begin
            kst <= K_IDLE;
            if (key == OFF2) run <= 1'b0;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'(ctrl);
      A_LOAD:  bus_rdata = load;
      A_CNT:   bus_rdata = count;
      A_KICK:  bus_rdata = last_kick;
      A_PEND:  bus_rdata = DATA_W'(pend);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/key_wdt_chk.sv
module key_wdt_chk #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              run,
  input logic [CTRL_W-1:0] ctrl,
  input logic [DATA_W-1:0] load,
  input logic [DATA_W-1:0] count,
  input logic [3:0]        pend,
  input logic              wdt_rst
);
  a_r4_count_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  a_r3_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(ctrl));
  a_r3_load_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(load));
  a_r6_pend_clears_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (($past(pend) & ~pend) == 4'b0));
  a_r8_rst_from_armed_tick: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> ($past(run) && $past(tick)));
  a_r1_arm_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(pend[2]));
endmodule

bind key_wdt key_wdt_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .ctrl(ctrl),
  .load(load), .count(count), .pend(pend), .wdt_rst(wdt_rst)
);

// File: tb/key_wdt_bench.sv
module key_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst;

  always #2 clk = ~clk;

  key_wdt u_key_wdt (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst));

  int n_chk = 0, n_bad = 0;

  bit          m_run, m_rst;
  int          m_ks, m_pre;
  logic [3:0]  m_ctrl;
  logic [31:0] m_load, m_cnt, m_kick;
  bit          m_pend [4];
  int          m_age [4];
  logic [31:0] m_sh [4];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int chan(input logic [2:0] a);
    case (a)
      3'd0: return 0;
      3'd1: return 1;
      3'd3: return 2;
      3'd4: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {28'd0, m_ctrl};
      3'd1: return m_load;
      3'd2: return m_cnt;
      3'd4: return m_kick;
      3'd5: return {28'd0, 1'(m_pend[3]), 1'(m_pend[2]), 1'(m_pend[1]), 1'(m_pend[0])};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R3";
      3'd2: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_run = 0; m_rst = 0; m_ks = 0; m_pre = 0; m_ctrl = 0;
    m_load = 32'hFFFF_FFFF; m_cnt = 0; m_kick = 0;
    for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_age[i] = 0; m_sh[i] = 0; end
  endtask

  task automatic model_step(input bit w, input logic [2:0] a, input logic [31:0] d, input bit t);
    bit          o_run = m_run;
    logic [31:0] o_load = m_load;
    int          mask = (1 << m_ctrl[2:0]) - 1;
    bit          due [4];
    int          ch;
    m_rst = 0;
    if (t && o_run) begin
      if (!m_ctrl[3] || m_pre == mask) begin
        m_pre = 0;
        if (m_cnt == 32'hFFFF_FFFF) begin m_rst = 1; m_cnt = o_load; end
        else m_cnt = m_cnt + 1;
      end else m_pre = m_pre + 1;
    end
    for (int i = 0; i < 4; i++) begin
      due[i] = m_pend[i] && t && (m_age[i] == 1);
      if (due[i]) m_pend[i] = 0;
      else if (m_pend[i] && t) m_age[i] = m_age[i] + 1;
    end
    if (due[0] && !o_run) m_ctrl = m_sh[0][3:0];
    if (due[1] && !o_run) m_load = m_sh[1];
    if (due[3]) begin
      if (m_sh[3] != m_kick) m_cnt = o_load;
      m_kick = m_sh[3];
    end
    if (due[2]) begin
      if (m_ks == 0) m_ks = (m_sh[2] == 32'hBBBB) ? 1 : (m_sh[2] == 32'hAAAA) ? 2 : 0;
      else if (m_ks == 1) begin
        m_ks = 0;
        if (m_sh[2] == 32'h4444) begin m_run = 1; m_cnt = o_load; m_pre = 0; end
      end else begin
        m_ks = 0;
        if (m_sh[2] == 32'h5555) m_run = 0;
      end
    end
    ch = chan(a);
    if (w && ch >= 0) begin m_sh[ch] = d; m_pend[ch] = 1; m_age[ch] = 0; end
  endtask

  task automatic cyc(input bit w, input logic [2:0] a, input logic [31:0] d,
                     input bit t, input string tag);
    @(negedge clk);
    bus_we = w; bus_addr = a; bus_wdata = d; tick = t;
    #1;
    if (!w) chk(tag, bus_rdata, exp_read(a));
    chk("R8", {31'd0, wdt_rst}, {31'd0, m_rst});
    @(posedge clk);
    model_step(w, a, d, t);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    cyc(1, a, d, 0, tag);
    cyc(0, 3'd5, 0, 1, tag);
    cyc(0, 3'd5, 0, 0, tag);
    cyc(0, 3'd5, 0, 1, tag);
    cyc(0, a, 0, 0, tag);
  endtask

  function automatic logic [31:0] pick(input logic [2:0] a);
    int r = $urandom % 8;
    case (a)
      3'd0: return 32'($urandom % 16);
      3'd1: return (r < 6) ? (32'hFFFF_FFF0 | 32'($urandom % 16)) : $urandom;
      3'd4: return 32'($urandom % 3);
      default: case (r)
        0, 1: return 32'hBBBB;
        2, 3: return 32'h4444;
        4:    return 32'hAAAA;
        5:    return 32'h5555;
        6:    return 32'h1BBBB;
        default: return $urandom;
      endcase
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9: watchdog expired, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    for (int a = 0; a < 8; a++) cyc(0, 3'(a), 0, 0, "R9");
    chk("R9", exp_read(3'd1), 32'hFFFF_FFFF);

    cyc(1, 3'd0, 32'hA, 0, "R6");
    cyc(0, 3'd5, 0, 0, "R6");
    chk("R6", bus_rdata, 32'h1);
    cyc(0, 3'd5, 0, 1, "R6");
    cyc(0, 3'd5, 0, 1, "R6");
    cyc(0, 3'd5, 0, 0, "R6");
    chk("R6", bus_rdata, 32'h0);
    cyc(0, 3'd0, 0, 0, "R4");
    chk("R4", bus_rdata, 32'hA);

    wr(3'd1, 32'hFFFF_FFF0, "R3");
    wr(3'd3, 32'hBBBB, "R1");
    wr(3'd3, 32'h4444, "R1");
    cyc(0, 3'd2, 0, 0, "R1");
    for (int i = 0; i < 8; i++) begin
      cyc(0, 3'd2, 0, 1, "R4");
      cyc(0, 3'd2, 0, 0, "R4");
    end
    wr(3'd1, 32'h5, "R3");
    wr(3'd0, 32'h0, "R3");
    wr(3'd4, 32'h1, "R5");
    cyc(0, 3'd2, 0, 0, "R5");
    wr(3'd4, 32'h1, "R5");
    cyc(0, 3'd2, 0, 0, "R5");
    for (int i = 0; i < 90; i++) begin
      cyc(0, 3'd2, 0, 1, "R8");
      cyc(0, 3'd2, 0, 0, "R8");
    end
    wr(3'd3, 32'hAAAA, "R7");
    wr(3'd3, 32'h1234, "R7");
    wr(3'd3, 32'h5555, "R7");
    cyc(0, 3'd2, 0, 1, "R7");
    cyc(0, 3'd2, 0, 0, "R7");
    wr(3'd3, 32'hAAAA, "R2");
    wr(3'd3, 32'h5555, "R2");
    for (int i = 0; i < 6; i++) cyc(0, 3'd2, 0, i % 2, "R2");
    wr(3'd1, 32'h5, "R3");

    for (int i = 0; i < 6000; i++) begin
      logic [2:0] a = 3'($urandom % 8);
      bit w = ($urandom % 10) < 3;
      bit t = ($urandom % 2) == 0;
      cyc(w, a, w ? pick(a) : 32'd0, t, tag_of(a));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule